// File: doc/BRIEF.md
# Move-Instruction Field Decoder with One-Shot Destination Prefix

This block decodes a 16-bit instruction word for a transport-triggered processor, where every operation is a single move from a source to a destination register. Arithmetic, logic and jumps are all expressed as moves to particular registers. The decoder splits each valid word into decoded fields:

- a source that is either an 8-bit immediate or a register given by module and index;
- a destination module;
- a 5-bit destination index.

The decoded fields are presented one cycle after the word is accepted.

A destination field has room for only three index bits. To reach the upper index locations of a module, software first writes a prefix value with an ordinary move whose destination is the prefix module (code 0xB). That word is flagged as a prefix write and produces no normal destination. The prefix value is latched and supplies the two high index bits to the very next valid instruction only, then clears back to zero. Cycles without a valid word leave the prefix untouched.

Top module: `mdec_top`

## Requirements
- R1: While reset is applied and on the first cycle after it, dec_valid, pfx_wr and every decoded field read zero, and the held prefix is zero, so the first decoded destination index has its high two bits at zero.
- R2: dec_valid is high in the cycle after instr_valid was sampled high, and low in the cycle after it was sampled low.
- R3: When instr[15] is 1, the source is an immediate. src_is_imm is 1, src_imm equals instr[7:0], and src_mod and src_idx are 0.
- R4: When instr[15] is 0, the source is a register. src_is_imm is 0, src_mod equals instr[3:0], src_idx equals instr[7:4], and src_imm is 0.
- R5: dst_mod equals instr[11:8], and dst_idx[2:0] equals the subindex instr[14:12].
- R6: A valid word with instr[11:8] equal to 0xB is a prefix write. pfx_wr is 1 for it and dst_idx[4:3] reads 0. The prefix loads instr[1:0] if the source is immediate, and 0 if the source is a register.
- R7: For a valid word that is not a prefix write, dst_idx[4:3] equals the held prefix. The prefix is then cleared, so the following non-prefix word sees 0.
- R8: A cycle with instr_valid low changes neither the held prefix nor any decoded field other than dec_valid and pfx_wr.
- R9: Two prefix writes in a row leave only the second value held. The first is discarded.
- R10: pfx_wr is high only in cycles where dec_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Fetched instruction word |
| dec_valid | output | 1 | Decoded fields belong to a word accepted last cycle |
| src_is_imm | output | 1 | Source is an immediate |
| src_imm | output | 8 | Immediate value (0 for register source) |
| src_mod | output | 4 | Source module (0 for immediate) |
| src_idx | output | 4 | Source index within module (0 for immediate) |
| dst_mod | output | 4 | Destination module |
| dst_idx | output | 5 | Extended destination index, prefix above subindex |
| pfx_wr | output | 1 | Decoded word is a prefix write |

## Verification
Directed words exercise several cases separately:

- immediate and register sources, to separate the two source formats;
- a prefix followed by one ordinary move and then another, to show that the prefix is consumed exactly once;
- a prefix with idle cycles before its consumer, to show that idle cycles neither clear nor spend it;
- back-to-back prefixes, to show the overwrite;
- a register-sourced prefix, to show the zero load.

Seeded random words follow. They are biased toward the prefix module and mixed with idle cycles, so every pairing of prefix, move and gap appears against the bench's own reference model.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
   localparam int unsigned INSTR_W_D = 16;
   localparam int unsigned SRC_W_D   = 8;
   localparam int unsigned MOD_W_D   = 4;
   localparam int unsigned PFX_W_D   = 2;
   localparam logic [3:0]  PFX_MOD_D = 4'hB;

   typedef enum logic {
      SRC_REG = 1'b0,
      SRC_IMM = 1'b1
   } src_fmt_e;
endpackage

// File: rtl/mdec_field_split.sv
module mdec_field_split
   import mdec_pkg::*;
#(
   parameter int unsigned INSTR_W = INSTR_W_D,
   parameter int unsigned SRC_W   = SRC_W_D,
   parameter int unsigned MOD_W   = MOD_W_D,
   parameter int unsigned PFX_W   = PFX_W_D,
   parameter logic [MOD_W-1:0] PFX_MOD = PFX_MOD_D[MOD_W-1:0],
   localparam int unsigned DST_W  = INSTR_W - 1 - SRC_W,
   localparam int unsigned SIDX_W = SRC_W - MOD_W,
   localparam int unsigned SUB_W  = DST_W - MOD_W
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               fmt_imm,
   output logic [SRC_W-1:0]   imm,
   output logic [MOD_W-1:0]   smod,
   output logic [SIDX_W-1:0]  sidx,
   output logic [MOD_W-1:0]   dmod,
   output logic [SUB_W-1:0]   dsub,
   output logic               is_pfx,
   output logic [PFX_W-1:0]   pfx_val
);
   localparam int unsigned FMT_BIT = INSTR_W - 1;

   src_fmt_e               fmt;
   logic [SRC_W-1:0]       src_raw;
   logic [DST_W-1:0]       dst_raw;

   always_comb begin
      fmt     = src_fmt_e'(instr[FMT_BIT]);
      src_raw = instr[SRC_W-1:0];
      dst_raw = instr[FMT_BIT-1:SRC_W];
   end

   always_comb begin
      fmt_imm = (fmt == SRC_IMM);
      dmod    = dst_raw[MOD_W-1:0];
      dsub    = dst_raw[DST_W-1:MOD_W];
      is_pfx  = (dst_raw[MOD_W-1:0] == PFX_MOD);
      if (fmt == SRC_IMM) begin
         imm  = src_raw;
         smod = '0;
         sidx = '0;
      end else begin
         imm  = '0;
         smod = src_raw[MOD_W-1:0];
         sidx = src_raw[SRC_W-1:MOD_W];
      end
   end

   always_comb begin
      if (fmt == SRC_IMM) pfx_val = src_raw[PFX_W-1:0];
      else                pfx_val = '0;
   end
endmodule

// File: rtl/mdec_prefix_state.sv
module mdec_prefix_state #(
   parameter int unsigned PFX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             is_pfx,
   input  logic [PFX_W-1:0] load_val,
   output logic [PFX_W-1:0] pfx_cur
);
   logic [PFX_W-1:0] pfx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfx_q <= '0;
      end else if (take) begin
         if (is_pfx) pfx_q <= load_val;
         else        pfx_q <= '0;
      end
   end

   assign pfx_cur = pfx_q;
endmodule

// File: rtl/mdec_out_stage.sv
module mdec_out_stage #(
   parameter bit          REG_OUT = 1'b1,
   parameter int unsigned SRC_W   = 8,
   parameter int unsigned MOD_W   = 4,
   parameter int unsigned SIDX_W  = 4,
   parameter int unsigned XIDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_imm_f,
   input  logic [SRC_W-1:0]  in_imm,
   input  logic [MOD_W-1:0]  in_smod,
   input  logic [SIDX_W-1:0] in_sidx,
   input  logic [MOD_W-1:0]  in_dmod,
   input  logic [XIDX_W-1:0] in_didx,
   input  logic              in_pfx,
   output logic              o_valid,
   output logic              o_imm_f,
   output logic [SRC_W-1:0]  o_imm,
   output logic [MOD_W-1:0]  o_smod,
   output logic [SIDX_W-1:0] o_sidx,
   output logic [MOD_W-1:0]  o_dmod,
   output logic [XIDX_W-1:0] o_didx,
   output logic              o_pfx
);
   generate
      if (REG_OUT) begin : g_reg
         logic              v_q, f_q, p_q;
         logic [SRC_W-1:0]  imm_q;
         logic [MOD_W-1:0]  smod_q, dmod_q;
         logic [SIDX_W-1:0] sidx_q;
         logic [XIDX_W-1:0] didx_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               p_q <= 1'b0;
            end else begin
               v_q <= in_valid;
               p_q <= in_valid & in_pfx;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f_q    <= 1'b0;
               imm_q  <= '0;
               smod_q <= '0;
               sidx_q <= '0;
               dmod_q <= '0;
               didx_q <= '0;
            end else if (in_valid) begin
               f_q    <= in_imm_f;
               imm_q  <= in_imm;
               smod_q <= in_smod;
               sidx_q <= in_sidx;
               dmod_q <= in_dmod;
               didx_q <= in_didx;
            end
         end

         assign o_valid = v_q;
         assign o_pfx   = p_q;
         assign o_imm_f = f_q;
         assign o_imm   = imm_q;
         assign o_smod  = smod_q;
         assign o_sidx  = sidx_q;
         assign o_dmod  = dmod_q;
         assign o_didx  = didx_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign o_valid = in_valid;
         assign o_pfx   = in_valid & in_pfx;
         assign o_imm_f = in_imm_f;
         assign o_imm   = in_imm;
         assign o_smod  = in_smod;
         assign o_sidx  = in_sidx;
         assign o_dmod  = in_dmod;
         assign o_didx  = in_didx;
      end
   endgenerate
endmodule

// File: rtl/mdec_top.sv
module mdec_top
   import mdec_pkg::*;
#(
   parameter int unsigned INSTR_W = INSTR_W_D,
   parameter int unsigned SRC_W   = SRC_W_D,
   parameter int unsigned MOD_W   = MOD_W_D,
   parameter int unsigned PFX_W   = PFX_W_D,
   parameter logic [MOD_W-1:0] PFX_MOD = PFX_MOD_D[MOD_W-1:0],
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned DST_W  = INSTR_W - 1 - SRC_W,
   localparam int unsigned SIDX_W = SRC_W - MOD_W,
   localparam int unsigned SUB_W  = DST_W - MOD_W,
   localparam int unsigned XIDX_W = SUB_W + PFX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [INSTR_W-1:0] instr,
   output logic              dec_valid,
   output logic              src_is_imm,
   output logic [SRC_W-1:0]  src_imm,
   output logic [MOD_W-1:0]  src_mod,
   output logic [SIDX_W-1:0] src_idx,
   output logic [MOD_W-1:0]  dst_mod,
   output logic [XIDX_W-1:0] dst_idx,
   output logic              pfx_wr
);
   generate
      if (SRC_W <= MOD_W) begin : g_bad_src
         $error("mdec_top: source field must be wider than module field");
      end
      if (DST_W <= MOD_W) begin : g_bad_dst
         $error("mdec_top: destination field must be wider than module field");
      end
      if (PFX_W == 0 || PFX_W > SRC_W) begin : g_bad_pfx
         $error("mdec_top: prefix width out of range");
      end
   endgenerate

   logic              f_imm, f_pfx;
   logic [SRC_W-1:0]  f_immv;
   logic [MOD_W-1:0]  f_smod, f_dmod;
   logic [SIDX_W-1:0] f_sidx;
   logic [SUB_W-1:0]  f_dsub;
   logic [PFX_W-1:0]  f_pval;
   logic [PFX_W-1:0]  pfx_cur;
   logic [XIDX_W-1:0] ext_idx;

   mdec_field_split #(
      .INSTR_W(INSTR_W), .SRC_W(SRC_W), .MOD_W(MOD_W),
      .PFX_W(PFX_W), .PFX_MOD(PFX_MOD)
   ) u_split (
      .instr   (instr),
      .fmt_imm (f_imm),
      .imm     (f_immv),
      .smod    (f_smod),
      .sidx    (f_sidx),
      .dmod    (f_dmod),
      .dsub    (f_dsub),
      .is_pfx  (f_pfx),
      .pfx_val (f_pval)
   );

   mdec_prefix_state #(.PFX_W(PFX_W)) u_pfx (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (instr_valid),
      .is_pfx   (f_pfx),
      .load_val (f_pval),
      .pfx_cur  (pfx_cur)
   );

   always_comb begin
      if (f_pfx) ext_idx = {{PFX_W{1'b0}}, f_dsub};
      else       ext_idx = {pfx_cur, f_dsub};
   end

   mdec_out_stage #(
      .REG_OUT(REG_OUT), .SRC_W(SRC_W), .MOD_W(MOD_W),
      .SIDX_W(SIDX_W), .XIDX_W(XIDX_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (instr_valid),
      .in_imm_f (f_imm),
      .in_imm   (f_immv),
      .in_smod  (f_smod),
      .in_sidx  (f_sidx),
      .in_dmod  (f_dmod),
      .in_didx  (ext_idx),
      .in_pfx   (f_pfx),
      .o_valid  (dec_valid),
      .o_imm_f  (src_is_imm),
      .o_imm    (src_imm),
      .o_smod   (src_mod),
      .o_sidx   (src_idx),
      .o_dmod   (dst_mod),
      .o_didx   (dst_idx),
      .o_pfx    (pfx_wr)
   );
endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned SRC_W   = 8,
   parameter int unsigned MOD_W   = 4,
   parameter int unsigned PFX_W   = 2,
   parameter logic [MOD_W-1:0] PFX_MOD = 4'hB,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned DST_W  = INSTR_W - 1 - SRC_W,
   localparam int unsigned SIDX_W = SRC_W - MOD_W,
   localparam int unsigned SUB_W  = DST_W - MOD_W,
   localparam int unsigned XIDX_W = SUB_W + PFX_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [INSTR_W-1:0] instr,
   input logic              dec_valid,
   input logic              src_is_imm,
   input logic [SRC_W-1:0]  src_imm,
   input logic [MOD_W-1:0]  src_mod,
   input logic [SIDX_W-1:0] src_idx,
   input logic [MOD_W-1:0]  dst_mod,
   input logic [XIDX_W-1:0] dst_idx,
   input logic              pfx_wr
);
   logic [PFX_W-1:0] pend_q;
   logic             in_pfx;
   logic unused_c;
   assign unused_c = ^{src_imm, src_mod, src_idx};

   assign in_pfx = (instr[SRC_W+MOD_W-1:SRC_W] == PFX_MOD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else if (instr_valid)
         pend_q <= (in_pfx && instr[INSTR_W-1]) ? instr[PFX_W-1:0] : '0;
   end

   a_r10_pfx_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_wr |-> dec_valid);

   a_r3_imm_no_reg_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && src_is_imm) |-> (src_mod == '0 && src_idx == '0));

   a_r6_pfx_low_index: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_wr |-> (dst_idx[XIDX_W-1:SUB_W] == '0));

   generate
      if (REG_OUT) begin : g_timed
         a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            instr_valid |=> dec_valid);

         a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !instr_valid |=> !dec_valid);

         a_r6_pfx_flagged: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_valid && in_pfx) |=> pfx_wr);

         a_r7_prefix_applied: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_valid && !in_pfx) |=> (dst_idx[XIDX_W-1:SUB_W] == $past(pend_q)));

         a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !instr_valid |=> ($stable(dst_idx) && $stable(dst_mod) && $stable(src_is_imm)));
      end
   endgenerate
endmodule

bind mdec_top mdec_checker #(
   .INSTR_W(INSTR_W), .SRC_W(SRC_W), .MOD_W(MOD_W),
   .PFX_W(PFX_W), .PFX_MOD(PFX_MOD), .REG_OUT(REG_OUT)
) u_mdec_chk (
   .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
   .dec_valid(dec_valid), .src_is_imm(src_is_imm), .src_imm(src_imm),
   .src_mod(src_mod), .src_idx(src_idx), .dst_mod(dst_mod),
   .dst_idx(dst_idx), .pfx_wr(pfx_wr)
);

// File: tb/mdec_top_bench.sv
module mdec_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = '0;
   logic        dec_valid, src_is_imm, pfx_wr;
   logic [7:0]  src_imm;
   logic [3:0]  src_mod, src_idx, dst_mod;
   logic [4:0]  dst_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // model state
   logic [1:0] m_pfx;
   logic       e_imm_f;
   logic [7:0] e_imm;
   logic [3:0] e_smod, e_sidx, e_dmod;
   logic [4:0] e_didx;

   always #4 clk = ~clk;

   mdec_top u_mdec_top (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .dec_valid(dec_valid), .src_is_imm(src_is_imm), .src_imm(src_imm),
      .src_mod(src_mod), .src_idx(src_idx), .dst_mod(dst_mod),
      .dst_idx(dst_idx), .pfx_wr(pfx_wr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input bit imm, input logic [2:0] sub,
                                       input logic [3:0] dmod, input logic [7:0] src);
      return {imm, sub, dmod, src};
   endfunction

   task automatic check_all(input bit v, input bit p);
      chk("R2", "dec_valid", dec_valid, v);
      chk("R10", "pfx_wr", pfx_wr, p);
      chk("R3", "src_is_imm", src_is_imm, e_imm_f);
      chk("R3", "src_imm", src_imm, e_imm);
      chk("R4", "src_mod", src_mod, e_smod);
      chk("R4", "src_idx", src_idx, e_sidx);
      chk("R5", "dst_mod", dst_mod, e_dmod);
      chk("R7", "dst_idx", dst_idx, e_didx);
   endtask

   // one cycle: drive at negedge, check after posedge
   task automatic step(input bit v, input logic [15:0] w);
      bit p;
      p = 1'b0;
      instr_valid = v;
      instr = w;
      if (v) begin
         p = (w[11:8] == 4'hB);
         e_imm_f = w[15];
         e_imm   = w[15] ? w[7:0] : 8'h00;
         e_smod  = w[15] ? 4'h0 : w[3:0];
         e_sidx  = w[15] ? 4'h0 : w[7:4];
         e_dmod  = w[11:8];
         e_didx  = p ? {2'b00, w[14:12]} : {m_pfx, w[14:12]};
         m_pfx   = p ? (w[15] ? w[1:0] : 2'b00) : 2'b00;
      end
      @(posedge clk);
      #2;
      check_all(v, p);
      @(negedge clk);
   endtask

   initial begin
      #1600000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd2024;
      void'($urandom(seed));
      m_pfx = 2'b00;
      e_imm_f = 0; e_imm = 0; e_smod = 0; e_sidx = 0; e_dmod = 0; e_didx = 0;
      repeat (3) @(negedge clk);
      // R1: reset values
      check_all(1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all(1'b0, 1'b0);
      // R1: first decode sees zero prefix
      step(1, mk(0, 3'd7, 4'h3, 8'h5A));
      // R3 immediate, R4 register
      step(1, mk(1, 3'd2, 4'h9, 8'hC3));
      step(1, mk(0, 3'd1, 4'h0, 8'hF1));
      // R6/R7: prefix 3 then consumer idx {11,101}=29, then cleared
      step(1, mk(1, 3'd4, 4'hB, 8'h03));
      step(1, mk(0, 3'd5, 4'h2, 8'h21));
      chk("R7", "consumed idx", dst_idx, 5'd29);
      step(1, mk(0, 3'd5, 4'h2, 8'h21));
      chk("R7", "cleared idx", dst_idx, 5'd5);
      // R8: idle gaps keep prefix and hold fields
      step(1, mk(1, 3'd0, 4'hB, 8'h02));
      step(0, mk(1, 3'd6, 4'h5, 8'hFF));
      chk("R8", "hold dst_idx", dst_idx, 5'd0);
      step(0, 16'hFFFF);
      step(1, mk(1, 3'd6, 4'h7, 8'h10));
      chk("R8", "prefix kept across idle", dst_idx, 5'd22);
      // R9: back-to-back prefixes
      step(1, mk(1, 3'd0, 4'hB, 8'h01));
      step(1, mk(1, 3'd0, 4'hB, 8'h02));
      step(1, mk(1, 3'd3, 4'h4, 8'h00));
      chk("R9", "second prefix wins", dst_idx, 5'd19);
      // R6: register-sourced prefix loads zero
      step(1, mk(1, 3'd0, 4'hB, 8'h03));
      step(1, mk(0, 3'd0, 4'hB, 8'h33));
      step(1, mk(0, 3'd7, 4'h1, 8'h45));
      chk("R6", "register prefix zero", dst_idx, 5'd7);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] w;
         bit v;
         w = 16'($urandom);
         if ($urandom_range(0, 3) == 0) w[11:8] = 4'hB;
         v = ($urandom_range(0, 9) < 7);
         step(v, w);
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule